// File: doc/BRIEF.md
# Host-Coprocessor Mailbox Interrupt Controller

This block is the control and status register set between an 8-bit PC-style host bus and an attached coprocessor board. Each side writes single-cycle command strobes, chosen by a small select code, and sees its own status byte. The two bytes are two views of one shared state. Interrupts run both ways through a handshake. The host posts an interrupt to the card, and only the card can acknowledge it. The card posts an interrupt to the host, and only the host can acknowledge it. The interrupt line toward the host is also gated by an enable bit. The host sets that bit once, and only a reset clears it.

The block also controls the coprocessor's start-up. After any reset the coprocessor is held in reset and halted. Two separate host commands remove the reset hold and the halt. The host can also fire a one-cycle NMI at the card. Parity and DMA-abort events reach the block as single-cycle pulses. They set sticky error bits that only the card can clear. A strap input chooses which of three host interrupt lines (IRQ2, IRQ3 or IRQ7) carries the host interrupt.

Top module: `mbx_ctrl`

## Requirements
- R1: After synchronous reset, `card_status` equals {4'b0, opt_open, 1'b0, 1'b0, cpu_type} and `host_status` equals {4'b0, 1'b1, diag}. `cop_halt` and `cop_reset_hold` are 1, and `host_irq`, `card_irq` and `card_nmi` are 0.
- R2: A card write with `card_sel`=3 sets bit6 of both status bytes. A `host_irq` line is driven only while bit6 and the enable bit (`card_status` bit2) are both set.
- R3: A host write with `host_sel`=1 sets `card_status` bit2. If bit6 is already pending, the routed `host_irq` line asserts in the same cycle the bit is set. Host acknowledges do not clear bit2; only a reset does.
- R4: A host write with `host_sel`=2 clears bit6 in both bytes and drops `host_irq`. If a card `card_sel`=3 write arrives in the same cycle, bit6 stays set.
- R5: A host write with `host_sel`=3 sets bit7 in both bytes and raises `card_irq`. A card write with `card_sel`=2 clears bit7 in both bytes and drops `card_irq`. If both arrive in the same cycle, bit7 stays set.
- R6: A `par_err` pulse sets bit5 and a `dma_abort` pulse sets bit4, in both bytes. The bits stay set until a card write with `card_sel`=1 clears both. A pulse that arrives in the same cycle as that clear leaves its bit set.
- R7: A host write with `host_sel`=7 returns all state to the R1 values, taking priority over any other command or pulse in the same cycle.
- R8: A host write with `host_sel`=5 clears `cop_reset_hold` only. A host write with `host_sel`=6 clears `cop_halt` and `host_status` bit3 only. Either may come first.
- R9: A host write with `host_sel`=4 makes `card_nmi` high for exactly one clock cycle, starting at the clock edge that samples the write.
- R10: `irq_route` selects the host line: 0 drives `host_irq[0]` (IRQ2), 1 drives `host_irq[1]` (IRQ3), 2 drives `host_irq[2]` (IRQ7), and 3 drives none. At most one line is high.
- R11: A write with select code 0 on either side changes nothing. Status bytes are plain outputs, and sampling them has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_sel | input | 3 | Host command select code |
| card_wr | input | 1 | Card write strobe, one cycle |
| card_sel | input | 2 | Card command select code |
| cpu_type | input | 1 | CPU type strap, shown in card status bit0 |
| opt_open | input | 1 | Option switch strap, shown in card status bit3 |
| diag | input | 3 | Diagnostic levels, shown in host status bits 2:0 |
| irq_route | input | 2 | Host interrupt line select strap |
| par_err | input | 1 | Parity error event pulse |
| dma_abort | input | 1 | DMA abort event pulse |
| host_status | output | 8 | Host view of status |
| card_status | output | 8 | Card view of status |
| host_irq | output | 3 | Host interrupt lines IRQ2, IRQ3, IRQ7 |
| card_irq | output | 1 | Interrupt request to the coprocessor |
| card_nmi | output | 1 | One-cycle NMI to the coprocessor |
| cop_halt | output | 1 | Coprocessor halt control |
| cop_reset_hold | output | 1 | Coprocessor reset hold control |

## Verification
Every flag is visible in at least one status byte on the cycle after the edge that changes it. A lost set, a missed clear or a wrong priority therefore shows up at the next sample after the command. A mismatch between the two bytes' upper nibbles means the two views have split. A stuck enable or a bad route shows up as a wrong `host_irq` pattern while an interrupt is pending. A bad halt or hold register shows up as wrong start-up control levels right after go, run or reset. An NMI that is too long or missing is caught within two cycles of the write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int STAT_W  = 8;
    localparam int HSEL_W  = 3;
    localparam int CSEL_W  = 2;
    localparam int DIAG_W  = 3;

    // status bit positions decoded by software on both sides
    localparam int B_CPU    = 0;
    localparam int B_IRQEN  = 2;
    localparam int B_OPT    = 3;
    localparam int B_RUNH   = 3;
    localparam int B_DMA    = 4;
    localparam int B_PAR    = 5;
    localparam int B_TOHOST = 6;
    localparam int B_TOCARD = 7;

    typedef enum logic [HSEL_W-1:0] {
        H_NONE   = 3'd0,
        H_IRQ_EN = 3'd1,
        H_ACK    = 3'd2,
        H_INT    = 3'd3,
        H_NMI    = 3'd4,
        H_GO     = 3'd5,
        H_RUN    = 3'd6,
        H_RST    = 3'd7
    } host_cmd_e;

    typedef enum logic [CSEL_W-1:0] {
        C_NONE    = 2'd0,
        C_CLR_ERR = 2'd1,
        C_ACK     = 2'd2,
        C_IRQ     = 2'd3
    } card_cmd_e;

    typedef struct packed {
        logic irq_en;
        logic h_ack;
        logic h_int;
        logic nmi;
        logic go;
        logic run;
        logic rst;
        logic c_clr_err;
        logic c_ack;
        logic c_irq;
    } mbx_cmd_t;

    typedef struct packed {
        logic irq_en;
        logic to_host;
        logic to_card;
        logic par;
        logic dma;
    } mbx_flags_t;

    function automatic logic [STAT_W-1:0] card_view(mbx_flags_t f, logic cpu, logic opt);
        logic [STAT_W-1:0] s;
        s           = '0;
        s[B_CPU]    = cpu;
        s[B_IRQEN]  = f.irq_en;
        s[B_OPT]    = opt;
        s[B_DMA]    = f.dma;
        s[B_PAR]    = f.par;
        s[B_TOHOST] = f.to_host;
        s[B_TOCARD] = f.to_card;
        return s;
    endfunction

    function automatic logic [STAT_W-1:0] host_view(mbx_flags_t f, logic halt,
                                                    logic [DIAG_W-1:0] dg);
        logic [STAT_W-1:0] s;
        s              = '0;
        s[DIAG_W-1:0]  = dg;
        s[B_RUNH]      = halt;
        s[B_DMA]       = f.dma;
        s[B_PAR]       = f.par;
        s[B_TOHOST]    = f.to_host;
        s[B_TOCARD]    = f.to_card;
        return s;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
(
    input  logic              host_wr,
    input  logic [HSEL_W-1:0] host_sel,
    input  logic              card_wr,
    input  logic [CSEL_W-1:0] card_sel,
    output mbx_cmd_t          cmd
);
    host_cmd_e hc;
    card_cmd_e cc;

    always_comb begin
        hc = host_cmd_e'(host_sel);
        cc = card_cmd_e'(card_sel);
        cmd           = '0;
        cmd.irq_en    = host_wr && (hc == H_IRQ_EN);
        cmd.h_ack     = host_wr && (hc == H_ACK);
        cmd.h_int     = host_wr && (hc == H_INT);
        cmd.nmi       = host_wr && (hc == H_NMI);
        cmd.go        = host_wr && (hc == H_GO);
        cmd.run       = host_wr && (hc == H_RUN);
        cmd.rst       = host_wr && (hc == H_RST);
        cmd.c_clr_err = card_wr && (cc == C_CLR_ERR);
        cmd.c_ack     = card_wr && (cc == C_ACK);
        cmd.c_irq     = card_wr && (cc == C_IRQ);
    end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mbx_cmd_t   cmd,
    input  logic       par_err,
    input  logic       dma_abort,
    output mbx_flags_t flags
);
    mbx_flags_t q;

    always_ff @(posedge clk) begin
        if (rst || cmd.rst) begin
            q <= '0;
        end else begin
            // enable is one-way: nothing but reset clears it
            q.irq_en  <= q.irq_en | cmd.irq_en;
            // in each pair a new set outranks a coincident clear
            q.to_host <= cmd.c_irq  ? 1'b1 : (cmd.h_ack     ? 1'b0 : q.to_host);
            q.to_card <= cmd.h_int  ? 1'b1 : (cmd.c_ack     ? 1'b0 : q.to_card);
            q.par     <= par_err    ? 1'b1 : (cmd.c_clr_err ? 1'b0 : q.par);
            q.dma     <= dma_abort  ? 1'b1 : (cmd.c_clr_err ? 1'b0 : q.dma);
        end
    end

    assign flags = q;
endmodule

// File: rtl/mbx_run_ctl.sv
module mbx_run_ctl
    import mbx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mbx_cmd_t cmd,
    output logic     halt,
    output logic     hold,
    output logic     nmi
);
    always_ff @(posedge clk) begin
        if (rst || cmd.rst) begin
            halt <= 1'b1;
            hold <= 1'b1;
            nmi  <= 1'b0;
        end else begin
            halt <= halt & ~cmd.run;
            hold <= hold & ~cmd.go;
            nmi  <= cmd.nmi;
        end
    end
endmodule

// File: rtl/mbx_irq_route.sv
module mbx_irq_route #(
    parameter int LINES   = 3,
    parameter int ROUTE_W = $clog2(LINES + 1)
) (
    input  logic               req,
    input  logic [ROUTE_W-1:0] route,
    output logic [LINES-1:0]   lines
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lines[i] = req && (route == ROUTE_W'(i));
    end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int IRQ_LINES = 3,
    parameter int ROUTE_W   = $clog2(IRQ_LINES + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_wr,
    input  logic [HSEL_W-1:0]   host_sel,
    input  logic                card_wr,
    input  logic [CSEL_W-1:0]   card_sel,
    input  logic                cpu_type,
    input  logic                opt_open,
    input  logic [DIAG_W-1:0]   diag,
    input  logic [ROUTE_W-1:0]  irq_route,
    input  logic                par_err,
    input  logic                dma_abort,
    output logic [STAT_W-1:0]   host_status,
    output logic [STAT_W-1:0]   card_status,
    output logic [IRQ_LINES-1:0] host_irq,
    output logic                card_irq,
    output logic                card_nmi,
    output logic                cop_halt,
    output logic                cop_reset_hold
);
    mbx_cmd_t   cmd;
    mbx_flags_t flags;
    logic       halt_q;

    mbx_decode u_dec (
        .host_wr  (host_wr),
        .host_sel (host_sel),
        .card_wr  (card_wr),
        .card_sel (card_sel),
        .cmd      (cmd)
    );

    mbx_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .par_err   (par_err),
        .dma_abort (dma_abort),
        .flags     (flags)
    );

    mbx_run_ctl u_run (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .halt (halt_q),
        .hold (cop_reset_hold),
        .nmi  (card_nmi)
    );

    mbx_irq_route #(.LINES(IRQ_LINES), .ROUTE_W(ROUTE_W)) u_route (
        .req   (flags.irq_en && flags.to_host),
        .route (irq_route),
        .lines (host_irq)
    );

    assign cop_halt    = halt_q;
    assign card_irq    = flags.to_card;
    assign card_status = card_view(flags, cpu_type, opt_open);
    assign host_status = host_view(flags, halt_q, diag);
endmodule

// File: rtl/mbx_ctrl_chk.sv
module mbx_ctrl_chk #(
    parameter int IRQ_LINES = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 host_wr,
    input logic [2:0]           host_sel,
    input logic                 card_wr,
    input logic [1:0]           card_sel,
    input logic                 par_err,
    input logic [7:0]           host_status,
    input logic [7:0]           card_status,
    input logic [IRQ_LINES-1:0] host_irq,
    input logic                 card_irq,
    input logic                 card_nmi,
    input logic                 cop_halt,
    input logic                 cop_reset_hold
);
    logic hrst;
    assign hrst = host_wr && (host_sel == 3'd7);

    a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (|host_irq) |-> (card_status[2] && card_status[6]));

    a_r10_one_line: assert property (@(posedge clk) disable iff (rst)
        $onehot0(host_irq));

    a_r5_card_irq_mirror: assert property (@(posedge clk) disable iff (rst)
        card_irq == host_status[7]);

    a_r6_views_agree: assert property (@(posedge clk) disable iff (rst)
        host_status[7:4] == card_status[7:4]);

    a_r6_par_sticky: assert property (@(posedge clk) disable iff (rst)
        (card_status[5] && !hrst && !(card_wr && card_sel == 2'd1)) |=> card_status[5]);

    a_r6_par_sets: assert property (@(posedge clk) disable iff (rst)
        (par_err && !hrst) |=> card_status[5]);

    a_r7_reset_cmd: assert property (@(posedge clk) disable iff (rst)
        hrst |=> (cop_halt && cop_reset_hold && card_status[7:4] == 4'h0
                  && !card_status[2] && host_irq == '0));

    a_r9_nmi_from_write: assert property (@(posedge clk) disable iff (rst)
        card_nmi |-> $past(host_wr && host_sel == 3'd4));

    a_r8_halt_no_reassert: assert property (@(posedge clk) disable iff (rst)
        $rose(cop_halt) |-> $past(hrst));
endmodule

bind mbx_ctrl mbx_ctrl_chk #(.IRQ_LINES(IRQ_LINES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .host_wr        (host_wr),
    .host_sel       (host_sel),
    .card_wr        (card_wr),
    .card_sel       (card_sel),
    .par_err        (par_err),
    .host_status    (host_status),
    .card_status    (card_status),
    .host_irq       (host_irq),
    .card_irq       (card_irq),
    .card_nmi       (card_nmi),
    .cop_halt       (cop_halt),
    .cop_reset_hold (cop_reset_hold)
);

// File: tb/tb_mbx_ctrl.sv
`timescale 1ns/1ps
module tb_mbx_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr = 1'b0;
    logic [2:0] host_sel = '0;
    logic       card_wr = 1'b0;
    logic [1:0] card_sel = '0;
    logic       cpu_type = 1'b1;
    logic       opt_open = 1'b1;
    logic [2:0] diag = 3'b101;
    logic [1:0] irq_route = 2'd0;
    logic       par_err = 1'b0;
    logic       dma_abort = 1'b0;
    logic [7:0] host_status, card_status;
    logic [2:0] host_irq;
    logic       card_irq, card_nmi, cop_halt, cop_reset_hold;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mbx_ctrl dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
        .card_wr(card_wr), .card_sel(card_sel), .cpu_type(cpu_type),
        .opt_open(opt_open), .diag(diag), .irq_route(irq_route),
        .par_err(par_err), .dma_abort(dma_abort), .host_status(host_status),
        .card_status(card_status), .host_irq(host_irq), .card_irq(card_irq),
        .card_nmi(card_nmi), .cop_halt(cop_halt), .cop_reset_hold(cop_reset_hold)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic ctl(string req, logic [7:0] hs, logic [7:0] cs, logic [2:0] irq,
                       logic ci, logic halt, logic hold);
        chk({req, " host_status"}, host_status, hs);
        chk({req, " card_status"}, card_status, cs);
        chk({req, " host_irq"}, {5'b0, host_irq}, {5'b0, irq});
        chk({req, " card_irq"}, {7'b0, card_irq}, {7'b0, ci});
        chk({req, " cop_halt"}, {7'b0, cop_halt}, {7'b0, halt});
        chk({req, " cop_reset_hold"}, {7'b0, cop_reset_hold}, {7'b0, hold});
    endtask

    task automatic hwr(logic [2:0] s);
        @(negedge clk); host_wr = 1'b1; host_sel = s;
        @(negedge clk); host_wr = 1'b0; host_sel = '0;
    endtask

    task automatic cwr(logic [1:0] s);
        @(negedge clk); card_wr = 1'b1; card_sel = s;
        @(negedge clk); card_wr = 1'b0; card_sel = '0;
    endtask

    task automatic t_reset;
        ctl("R1", 8'h0D, 8'h09, 3'b000, 1'b0, 1'b1, 1'b1);
        chk("R1 card_nmi", {7'b0, card_nmi}, 8'h00);
    endtask

    task automatic t_irq_path;
        cwr(2'd3);
        ctl("R2 pending no enable", 8'h4D, 8'h49, 3'b000, 1'b0, 1'b1, 1'b1);
        hwr(3'd1);
        ctl("R3 enable late", 8'h4D, 8'h4D, 3'b001, 1'b0, 1'b1, 1'b1);
        hwr(3'd2);
        ctl("R4 ack", 8'h0D, 8'h0D, 3'b000, 1'b0, 1'b1, 1'b1);
        hwr(3'd2);
        ctl("R4 ack when clear", 8'h0D, 8'h0D, 3'b000, 1'b0, 1'b1, 1'b1);
        cwr(2'd3);
        ctl("R3 enable sticky", 8'h4D, 8'h4D, 3'b001, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_route;
        irq_route = 2'd1; #1;
        chk("R10 route IRQ3", {5'b0, host_irq}, 8'h02);
        irq_route = 2'd2; #1;
        chk("R10 route IRQ7", {5'b0, host_irq}, 8'h04);
        irq_route = 2'd3; #1;
        chk("R10 route none", {5'b0, host_irq}, 8'h00);
        irq_route = 2'd0; #1;
        chk("R10 route IRQ2", {5'b0, host_irq}, 8'h01);
        hwr(3'd2);
        chk("R4 ack after route", card_status, 8'h0D);
    endtask

    task automatic t_card_int;
        hwr(3'd3);
        ctl("R5 interrupt card", 8'h8D, 8'h8D, 3'b000, 1'b1, 1'b1, 1'b1);
        cwr(2'd2);
        ctl("R5 card ack", 8'h0D, 8'h0D, 3'b000, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_errors;
        @(negedge clk); par_err = 1'b1;
        @(negedge clk); par_err = 1'b0;
        chk("R6 parity set", card_status, 8'h2D);
        repeat (3) @(negedge clk);
        chk("R6 parity sticky", host_status, 8'h2D);
        @(negedge clk); dma_abort = 1'b1;
        @(negedge clk); dma_abort = 1'b0;
        chk("R6 dma set", card_status, 8'h3D);
        cwr(2'd1);
        ctl("R6 clear errors", 8'h0D, 8'h0D, 3'b000, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_collide;
        @(negedge clk); par_err = 1'b1; card_wr = 1'b1; card_sel = 2'd1;
        @(negedge clk); par_err = 1'b0; card_wr = 1'b0; card_sel = '0;
        chk("R6 pulse beats clear", card_status, 8'h2D);
        cwr(2'd1);
        cwr(2'd3);
        @(negedge clk); host_wr = 1'b1; host_sel = 3'd2; card_wr = 1'b1; card_sel = 2'd3;
        @(negedge clk); host_wr = 1'b0; host_sel = '0;  card_wr = 1'b0; card_sel = '0;
        chk("R4 set beats ack", card_status, 8'h4D);
        hwr(3'd2);
        hwr(3'd3);
        @(negedge clk); host_wr = 1'b1; host_sel = 3'd3; card_wr = 1'b1; card_sel = 2'd2;
        @(negedge clk); host_wr = 1'b0; host_sel = '0;  card_wr = 1'b0; card_sel = '0;
        chk("R5 set beats ack", {7'b0, card_irq}, 8'h01);
        cwr(2'd2);
        chk("R5 cleanup", card_status, 8'h0D);
    endtask

    task automatic t_noop;
        cwr(2'd3);
        hwr(3'd3);
        hwr(3'd0);
        cwr(2'd0);
        repeat (2) @(negedge clk);
        ctl("R11 select zero", 8'hCD, 8'hCD, 3'b001, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_go_run;
        hwr(3'd6);
        chk("R8 run clears halt", {7'b0, cop_halt}, 8'h00);
        chk("R8 run leaves hold", {7'b0, cop_reset_hold}, 8'h01);
        chk("R8 run bit", host_status, 8'hC5);
        hwr(3'd5);
        chk("R8 go clears hold", {7'b0, cop_reset_hold}, 8'h00);
        chk("R8 go leaves halt", {7'b0, cop_halt}, 8'h00);
    endtask

    task automatic t_nmi;
        chk("R9 idle", {7'b0, card_nmi}, 8'h00);
        hwr(3'd4);
        chk("R9 pulse", {7'b0, card_nmi}, 8'h01);
        @(negedge clk);
        chk("R9 one cycle", {7'b0, card_nmi}, 8'h00);
    endtask

    task automatic t_host_reset;
        @(negedge clk); par_err = 1'b1;
        @(negedge clk); par_err = 1'b0;
        @(negedge clk); host_wr = 1'b1; host_sel = 3'd7; card_wr = 1'b1; card_sel = 2'd3;
                        dma_abort = 1'b1;
        @(negedge clk); host_wr = 1'b0; host_sel = '0; card_wr = 1'b0; card_sel = '0;
                        dma_abort = 1'b0;
        ctl("R7 host reset", 8'h0D, 8'h09, 3'b000, 1'b0, 1'b1, 1'b1);
        cwr(2'd3);
        chk("R7 enable cleared", {5'b0, host_irq}, 8'h00);
        hwr(3'd2);
    endtask

    initial begin
        #50000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_irq_path();
        t_route();
        t_card_int();
        t_errors();
        t_collide();
        t_noop();
        t_go_run();
        t_nmi();
        t_host_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule